// File: doc/BRIEF.md
# Queued SPI Master with End-of-Queue Control

This block is an SPI master that runs a queue of transfers without help from software. Each transmit entry carries a 16-bit data word and two control bits. The first bit marks the entry as the last one of the current queue. The second bit restarts the frame counter from that frame. Entries come in on a valid/ready stream and wait in a four-entry transmit FIFO. Each frame is shifted out MSB first in SPI mode 0, and the word received during that frame goes into a four-entry receive FIFO. Software reads that FIFO through a second valid/ready stream.

When the frame marked as last completes, the block raises an end-of-queue flag and stops. No further frame starts, so nothing more is sent and nothing more is received. To switch queues, software first drains the receive FIFO. It then flushes either FIFO if needed, optionally rewrites the frame counter, and writes 1 to the flag-clear input to resume.

The serial clock is set by a 2-bit prescaler code and a scaler exponent. A module-disable input stops new frames from starting, and while it is high, software cannot clear the flag or write the counter.

Back-pressure works as follows:
- The transmit stream accepts a word on a clock edge where `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` is low while four entries are held.
- The receive stream hands over a word on a clock edge where `rx_valid_o` and `rx_ready_i` are both high.
- A full receive FIFO holds back the next frame. Received data is never dropped.

Top module: `qspi_master`

## Requirements
- R1: A transmit entry is accepted on a clock edge where `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` is low exactly when `tx_count_o` equals 4, and `tx_count_o` gives the number of entries held.
- R2: Each frame holds `cs_n_o` low for 16 SCK periods. SCK idles low and is low whenever `cs_n_o` is high. MOSI carries the entry's data MSB first and is stable at each rising SCK edge.
- R3: The MISO bit is sampled at each rising SCK edge, and the 16-bit word (first bit as MSB) is pushed into the receive FIFO and offered on `rx_data_o`/`rx_valid_o`. No frame starts while the receive FIFO holds 4 words.
- R4: One SCK half period lasts P·2^`br_i` clock cycles. P is 2, 3, 5 or 7 for `pre_i` codes 0, 1, 2 and 3. Both fields must be held constant while a frame runs.
- R5: When a frame whose entry had the end-of-queue bit set completes, `eoq_flag_o` goes high and `running_o` goes low. No frame starts while the flag is high, even if entries are waiting.
- R6: A one-cycle pulse on `eoq_clr_i` clears the flag when the module is enabled. Waiting entries then resume.
- R7: A pulse on `clr_txf_i` empties the transmit FIFO, and a pulse on `clr_rxf_i` empties the receive FIFO. Each takes effect at the next clock edge.
- R8: `tcnt_o` resets to 0, goes up by one for each completed frame, and wraps from 0xFFFF to 0.
- R9: A frame whose entry had the counter-clear bit set leaves `tcnt_o` at 1 when it completes.
- R10: A pulse on `tcnt_wr_i` while the module is enabled loads `tcnt_wdata_i` into the counter at the next edge.
- R11: While `mdis_i` is high, no new frame starts and `running_o` is low. Counter writes and flag clears have no effect.
- R12: `rx_count_o` gives the number of received words held. `rx_nonempty_o` is high exactly when that count is non-zero, and both update after each pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Transmit entry valid |
| tx_ready_o | output | 1 | Transmit FIFO has space |
| tx_data_i | input | 16 | Data word of the entry |
| tx_eoq_i | input | 1 | Entry is the last of its queue |
| tx_ctcnt_i | input | 1 | Entry restarts the frame counter |
| rx_valid_o | output | 1 | Received word available |
| rx_ready_i | input | 1 | Consumer takes the received word |
| rx_data_o | output | 16 | Oldest received word |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Chip select, active low |
| pre_i | input | 2 | Prescaler code |
| br_i | input | 3 | Scaler exponent |
| mdis_i | input | 1 | Module disable |
| eoq_clr_i | input | 1 | Write-1 pulse clearing the end-of-queue flag |
| clr_txf_i | input | 1 | Flush transmit FIFO |
| clr_rxf_i | input | 1 | Flush receive FIFO |
| tcnt_wr_i | input | 1 | Frame counter write strobe |
| tcnt_wdata_i | input | 16 | Frame counter write value |
| tcnt_o | output | 16 | Frame counter |
| eoq_flag_o | output | 1 | End-of-queue flag |
| running_o | output | 1 | High while frames may start |
| tx_count_o | output | 3 | Entries in the transmit FIFO |
| rx_count_o | output | 3 | Words in the receive FIFO |
| rx_nonempty_o | output | 1 | Receive FIFO not empty |

## Verification
The bench targets the cycle in which the last frame completes. A design that lets one more frame start there would send a word from the next queue before the flag rises.

A five-entry queue that is never drained fills the receive FIFO. A design that ignores receive back-pressure would either overwrite stored words or run the fifth frame; the bench then flushes the receive FIFO and expects exactly that fifth word.

The bench also checks the following:
- The counter wraps at 0xFFFF and the counter-clear entry restarts it. An off-by-one error here shows up as a wrong `tcnt_o`.
- The SCK period is measured for random prescaler and scaler pairs.
- With the module disabled, writes and flag clears are applied and the bench confirms that nothing changed.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

  parameter int unsigned QSPI_DW = 16;

  typedef struct packed {
    logic                 eoq;
    logic                 ctcnt;
    logic [QSPI_DW-1:0]   data;
  } qspi_cmd_t;

  typedef enum logic {ENG_IDLE = 1'b0, ENG_SHIFT = 1'b1} eng_state_e;

  function automatic logic [2:0] prescale_value(input logic [1:0] code);
    logic [2:0] v;
    case (code)
      2'd0:    v = 3'd2;
      2'd1:    v = 3'd3;
      2'd2:    v = 3'd5;
      default: v = 3'd7;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/qspi_fifo.sv
module qspi_fifo #(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  output logic          full_o,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          wr_ok, rd_ok;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr_ok   = push_i && !full_o && !flush_i;
  assign rd_ok   = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= ptr_next(wp_q);
      if (rd_ok) rp_q <= ptr_next(rp_q);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R1
  AST_FIFO_PUSH_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !pop_i && !flush_i) |=> (cnt_q == $past(cnt_q) + CW'(1))); // R1
  AST_FIFO_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/qspi_baud.sv
module qspi_baud
  import qspi_pkg::*;
#(
  parameter int unsigned BR_W = 3,
  localparam int unsigned HC_W = 3 + (1 << BR_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [1:0]      pre_i,
  input  logic [BR_W-1:0] br_i,
  output logic            tick_o
);

  logic [HC_W-1:0] half;
  logic [HC_W-1:0] cnt_q;

  assign half   = HC_W'(prescale_value(pre_i)) << br_i;
  assign tick_o = en_i && (cnt_q == half - HC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                   cnt_q <= cnt_q + HC_W'(1);
  end

  AST_BAUD_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < half)); // R4

endmodule

// File: rtl/qspi_shift.sv
module qspi_shift
  import qspi_pkg::*;
#(
  parameter int unsigned DW = QSPI_DW,
  localparam int unsigned EC_W = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  input  logic          tick_i,
  input  logic          miso_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o,
  output logic          sck_o,
  output logic          mosi_o,
  output logic          cs_n_o
);

  eng_state_e      st_q;
  logic [DW-1:0]   txsh_q, rxsh_q;
  logic [EC_W-1:0] ecnt_q;
  logic            sck_q, cs_n_q, done_q;

  assign busy_o = (st_q == ENG_SHIFT);
  assign done_o = done_q;
  assign rx_o   = rxsh_q;
  assign sck_o  = sck_q;
  assign cs_n_o = cs_n_q;
  assign mosi_o = txsh_q[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ENG_IDLE;
      txsh_q <= '0;
      rxsh_q <= '0;
      ecnt_q <= '0;
      sck_q  <= 1'b0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == ENG_IDLE) begin
        if (start_i) begin
          st_q   <= ENG_SHIFT;
          cs_n_q <= 1'b0;
          sck_q  <= 1'b0;
          txsh_q <= data_i;
          ecnt_q <= '0;
        end
      end else if (tick_i) begin
        if (!sck_q) begin
          sck_q  <= 1'b1;
          rxsh_q <= {rxsh_q[DW-2:0], miso_i};
        end else begin
          sck_q  <= 1'b0;
          ecnt_q <= ecnt_q + EC_W'(1);
          if (ecnt_q == EC_W'(DW - 1)) begin
            st_q   <= ENG_IDLE;
            cs_n_q <= 1'b1;
            done_q <= 1'b1;
          end else begin
            txsh_q <= txsh_q << 1;
          end
        end
      end
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_q |-> !sck_q); // R2
  AST_DONE_RAISES_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> cs_n_q); // R2
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sck_q && $past(busy_o)) |-> $stable(mosi_o)); // R2

endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned BR_W       = 3,
  parameter int unsigned CNT_W      = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              tx_valid_i,
  output logic                              tx_ready_o,
  input  logic [QSPI_DW-1:0]                tx_data_i,
  input  logic                              tx_eoq_i,
  input  logic                              tx_ctcnt_i,
  output logic                              rx_valid_o,
  input  logic                              rx_ready_i,
  output logic [QSPI_DW-1:0]                rx_data_o,
  output logic                              sck_o,
  output logic                              mosi_o,
  input  logic                              miso_i,
  output logic                              cs_n_o,
  input  logic [1:0]                        pre_i,
  input  logic [BR_W-1:0]                   br_i,
  input  logic                              mdis_i,
  input  logic                              eoq_clr_i,
  input  logic                              clr_txf_i,
  input  logic                              clr_rxf_i,
  input  logic                              tcnt_wr_i,
  input  logic [CNT_W-1:0]                  tcnt_wdata_i,
  output logic [CNT_W-1:0]                  tcnt_o,
  output logic                              eoq_flag_o,
  output logic                              running_o,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]   tx_count_o,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]   rx_count_o,
  output logic                              rx_nonempty_o
);

  localparam int unsigned DW    = QSPI_DW;
  localparam int unsigned CMD_W = $bits(qspi_cmd_t);

  qspi_cmd_t       tx_in, tx_head;
  logic [CMD_W-1:0] tx_head_raw;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic            start, busy, eng_done, tick;
  logic [DW-1:0]   eng_rx;
  logic            eoq_q, cur_eoq_q, cur_ctcnt_q;
  logic [CNT_W-1:0] tcnt_q;
  logic            sw_tcnt_wr;

  assign tx_in   = '{eoq: tx_eoq_i, ctcnt: tx_ctcnt_i, data: tx_data_i};
  assign tx_head = qspi_cmd_t'(tx_head_raw);

  qspi_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (clr_txf_i),
    .push_i  (tx_valid_i),
    .wdata_i (tx_in),
    .full_o  (tx_full),
    .pop_i   (start),
    .rdata_o (tx_head_raw),
    .empty_o (tx_empty),
    .count_o (tx_count_o)
  );

  qspi_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (clr_rxf_i),
    .push_i  (eng_done),
    .wdata_i (eng_rx),
    .full_o  (rx_full),
    .pop_i   (rx_ready_i),
    .rdata_o (rx_data_o),
    .empty_o (rx_empty),
    .count_o (rx_count_o)
  );

  qspi_baud #(.BR_W(BR_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy),
    .pre_i  (pre_i),
    .br_i   (br_i),
    .tick_o (tick)
  );

  qspi_shift #(.DW(DW)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .data_i  (tx_head.data),
    .tick_i  (tick),
    .miso_i  (miso_i),
    .busy_o  (busy),
    .done_o  (eng_done),
    .rx_o    (eng_rx),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .cs_n_o  (cs_n_o)
  );

  assign running_o     = !eoq_q && !mdis_i;
  assign start         = running_o && !busy && !eng_done && !tx_empty && !rx_full && !clr_txf_i;
  assign tx_ready_o    = !tx_full;
  assign rx_valid_o    = !rx_empty;
  assign rx_nonempty_o = !rx_empty;
  assign eoq_flag_o    = eoq_q;
  assign tcnt_o        = tcnt_q;
  assign sw_tcnt_wr    = tcnt_wr_i && !mdis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_eoq_q   <= 1'b0;
      cur_ctcnt_q <= 1'b0;
    end else if (start) begin
      cur_eoq_q   <= tx_head.eoq;
      cur_ctcnt_q <= tx_head.ctcnt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     eoq_q <= 1'b0;
    else if (eng_done && cur_eoq_q)  eoq_q <= 1'b1;
    else if (eoq_clr_i && !mdis_i)   eoq_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tcnt_q <= '0;
    else if (sw_tcnt_wr) tcnt_q <= tcnt_wdata_i;
    else if (eng_done)   tcnt_q <= cur_ctcnt_q ? CNT_W'(1) : tcnt_q + CNT_W'(1);
  end

  AST_EOQ_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done && cur_eoq_q) |=> (eoq_q && !running_o)); // R5
  AST_STOPPED_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoq_q && !busy) |=> !busy); // R5
  AST_RX_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done |-> !rx_full); // R3
  AST_MDIS_TCNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdis_i && !eng_done) |=> $stable(tcnt_q)); // R11
  AST_CTCNT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done && cur_ctcnt_q && !sw_tcnt_wr) |=> (tcnt_q == CNT_W'(1))); // R9

endmodule

// File: tb/qspi_master_tb_top.sv
module qspi_master_tb_top;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_valid = 1'b0, tx_eoq = 1'b0, tx_ctcnt = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_ready, rx_valid, rx_nonempty;
  logic        rx_ready = 1'b0;
  logic [15:0] rx_data;
  logic        sck, mosi, cs_n;
  logic        miso = 1'b0;
  logic [1:0]  pre = 2'd0;
  logic [2:0]  br = 3'd0;
  logic        mdis = 1'b0, eoq_clr = 1'b0, clr_txf = 1'b0, clr_rxf = 1'b0, tcnt_wr = 1'b0;
  logic [15:0] tcnt_wdata = '0, tcnt;
  logic        eoq_flag, running;
  logic [2:0]  tx_count, rx_count;

  always #10 clk = ~clk;

  qspi_master dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
    .tx_eoq_i(tx_eoq), .tx_ctcnt_i(tx_ctcnt),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n),
    .pre_i(pre), .br_i(br), .mdis_i(mdis), .eoq_clr_i(eoq_clr),
    .clr_txf_i(clr_txf), .clr_rxf_i(clr_rxf),
    .tcnt_wr_i(tcnt_wr), .tcnt_wdata_i(tcnt_wdata), .tcnt_o(tcnt),
    .eoq_flag_o(eoq_flag), .running_o(running),
    .tx_count_o(tx_count), .rx_count_o(rx_count), .rx_nonempty_o(rx_nonempty)
  );

  int          checks = 0, fails = 0;
  bit          finished = 1'b0, tb_ready = 1'b0;
  int unsigned cyc = 0;
  always @(negedge clk) cyc++;

  // serial slave model and MOSI monitor
  logic [15:0] sl_q[$], exp_mosi_q[$], exp_rx_q[$], mon_q[$];
  logic [15:0] sword = '0, cap = '0;
  int          nbits = 0, frames = 0;
  int unsigned r0 = 0, r1 = 0;

  always @(negedge cs_n) if (tb_ready) begin
    sword = (sl_q.size() > 0) ? sl_q.pop_front() : 16'h0;
    miso  = sword[15];
    nbits = 0;
  end
  always @(negedge sck) if (tb_ready && !cs_n) begin
    sword = sword << 1;
    miso  = sword[15];
  end
  always @(posedge sck) if (tb_ready) begin
    if (nbits == 0) r0 = cyc;
    if (nbits == 1) r1 = cyc;
    cap = {cap[14:0], mosi};
    nbits++;
  end
  always @(posedge cs_n) if (tb_ready) begin
    mon_q.push_back(cap);
    frames++;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int half_cycles(input int p, input int b);
    int v;
    case (p)
      0: v = 2;
      1: v = 3;
      2: v = 5;
      default: v = 7;
    endcase
    return v << b;
  endfunction

  function automatic logic [15:0] next_tcnt(input logic [15:0] t, input bit c);
    return c ? 16'd1 : t + 16'd1;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [15:0] d, input bit e, input bit c, input logic [15:0] s, input bit track);
    if (track) begin
      sl_q.push_back(s);
      exp_mosi_q.push_back(d);
      exp_rx_q.push_back(s);
    end
    tx_valid = 1'b1; tx_data = d; tx_eoq = e; tx_ctcnt = c;
    forever begin
      if (tx_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    tx_valid = 1'b0;
  endtask

  task automatic pop_check(input string req);
    logic [15:0] d;
    rx_ready = 1'b1;
    forever begin
      if (rx_valid) begin d = rx_data; @(negedge clk); break; end
      @(negedge clk);
    end
    rx_ready = 1'b0;
    chk(req, "rx word", d, exp_rx_q.pop_front());
  endtask

  task automatic pulse_clr(input int which);
    case (which)
      0: eoq_clr = 1'b1;
      1: clr_txf = 1'b1;
      default: clr_rxf = 1'b1;
    endcase
    @(negedge clk);
    eoq_clr = 1'b0; clr_txf = 1'b0; clr_rxf = 1'b0;
  endtask

  task automatic write_tcnt(input logic [15:0] v);
    tcnt_wr = 1'b1; tcnt_wdata = v;
    @(negedge clk);
    tcnt_wr = 1'b0;
  endtask

  task automatic wait_eoq();
    while (!eoq_flag) @(negedge clk);
  endtask

  task automatic check_mosi();
    chk("R2", "frames seen vs expected", mon_q.size(), exp_mosi_q.size());
    while (mon_q.size() > 0 && exp_mosi_q.size() > 0)
      chk("R2", "mosi word", mon_q.pop_front(), exp_mosi_q.pop_front());
    mon_q.delete(); exp_mosi_q.delete();
  endtask

  logic [15:0] tmod = '0;

  initial begin
    int unsigned seed;
    int f0;
    seed = $urandom(32'h51A7);
    step(3);
    rst_n = 1'b1;
    step(1);
    tb_ready = 1'b1;
    // reset state
    chk("R5", "eoq flag after reset", eoq_flag, 1'b0);
    chk("R2", "cs_n idle", cs_n, 1'b1);
    chk("R2", "sck idle", sck, 1'b0);
    chk("R1", "tx_ready after reset", tx_ready, 1'b1);
    chk("R12", "rx_nonempty after reset", rx_nonempty, 1'b0);
    chk("R8", "tcnt after reset", tcnt, 16'h0);

    // R11 / R1 / R7: disabled module, fill tx fifo, writes ignored, then flush
    mdis = 1'b1;
    step(1);
    chk("R11", "running while disabled", running, 1'b0);
    for (int i = 0; i < DEPTH; i++) push(16'h1000 + 16'(i), 1'b0, 1'b0, 16'h0, 1'b0);
    chk("R1", "tx_count when full", tx_count, 3'd4);
    chk("R1", "tx_ready when full", tx_ready, 1'b0);
    write_tcnt(16'h1234);
    step(200);
    chk("R11", "tcnt write ignored", tcnt, 16'h0);
    chk("R11", "no frame while disabled", frames, 0);
    pulse_clr(1);
    chk("R7", "tx flush", tx_count, 3'd0);
    mdis = 1'b0;

    // R4 / R5: single eoq frame with pre=1, br=1
    pre = 2'd1; br = 3'd1;
    push(16'hA5C3, 1'b1, 1'b0, 16'h3C5A, 1'b1);
    wait_eoq();
    step(1);
    tmod = 16'd1;
    chk("R5", "eoq flag set", eoq_flag, 1'b1);
    chk("R5", "running low when stopped", running, 1'b0);
    chk("R4", "sck period", r1 - r0, 2 * half_cycles(1, 1));
    chk("R12", "rx_count after frame", rx_count, 3'd1);
    pop_check("R3");
    chk("R12", "rx_nonempty after pop", rx_nonempty, 1'b0);
    chk("R8", "tcnt after one frame", tcnt, tmod);
    check_mosi();

    // R5 / R6: entry waiting while stopped, then restart
    f0 = frames;
    push(16'h0F0F, 1'b0, 1'b0, 16'hF00F, 1'b1);
    step(300);
    chk("R5", "no frame while stopped", frames, f0);
    chk("R5", "entry waits while stopped", tx_count, 3'd1);
    pulse_clr(0);
    chk("R6", "flag cleared", eoq_flag, 1'b0);
    chk("R6", "running again", running, 1'b1);
    while (frames == f0) @(negedge clk);
    step(2);
    pop_check("R6");
    tmod = next_tcnt(tmod, 1'b0);
    chk("R8", "tcnt after restart frame", tcnt, tmod);
    check_mosi();

    // R3 / R7 / R12: receive FIFO fills, fifth frame held back, rx flush
    pre = 2'd0; br = 3'd0;
    f0 = frames;
    for (int i = 0; i < 5; i++)
      push(16'h8001 + 16'(i * 16'h1111), i == 4, 1'b0, 16'h4000 + 16'(i * 3), 1'b1);
    while (frames < f0 + 4) @(negedge clk);
    step(100);
    chk("R3", "fifth frame held while rx full", frames, f0 + 4);
    chk("R12", "rx_count full", rx_count, 3'd4);
    chk("R12", "rx_nonempty when full", rx_nonempty, 1'b1);
    chk("R3", "entry still queued", tx_count, 3'd1);
    pulse_clr(2);
    chk("R7", "rx flush", rx_count, 3'd0);
    repeat (4) void'(exp_rx_q.pop_front());
    wait_eoq();
    step(1);
    pop_check("R3");
    for (int i = 0; i < 5; i++) tmod = next_tcnt(tmod, 1'b0);
    chk("R8", "tcnt after five frames", tcnt, tmod);
    check_mosi();
    pulse_clr(0);

    // R10 / R8: software write then wrap
    write_tcnt(16'hFFFE);
    chk("R10", "tcnt software write", tcnt, 16'hFFFE);
    push(16'h1357, 1'b0, 1'b0, 16'h2468, 1'b1);
    push(16'hFDB9, 1'b1, 1'b0, 16'h9BDF, 1'b1);
    wait_eoq();
    step(1);
    chk("R8", "tcnt wrap", tcnt, 16'h0);
    pop_check("R3");
    pop_check("R3");
    check_mosi();
    tmod = 16'h0;
    pulse_clr(0);

    // random queues
    for (int q = 0; q < 6; q++) begin
      int p, b, len;
      bit used_c;
      logic [15:0] dq[6], sq[6];
      bit cq[6];
      p = int'($urandom % 4); b = int'($urandom % 3);
      len = 1 + int'($urandom % 6);
      pre = 2'(p); br = 3'(b);
      used_c = 1'b0;
      for (int i = 0; i < len; i++) begin
        dq[i] = 16'($urandom); sq[i] = 16'($urandom);
        cq[i] = (i == 0) && ((q == 0) || ($urandom % 2 == 1));
        if (cq[i]) used_c = 1'b1;
        tmod = next_tcnt(tmod, cq[i]);
      end
      fork
        for (int i = 0; i < len; i++) push(dq[i], i == len - 1, cq[i], sq[i], 1'b1);
        for (int i = 0; i < len; i++) pop_check("R3");
      join
      wait_eoq();
      step(1);
      chk(used_c ? "R9" : "R8", "tcnt after queue", tcnt, tmod);
      chk("R4", "sck period random", r1 - r0, 2 * half_cycles(p, b));
      chk("R5", "stopped after queue", running, 1'b0);
      check_mosi();
      if (q != 5) begin
        pulse_clr(1);
        pulse_clr(2);
        pulse_clr(0);
        chk("R6", "flag cleared between queues", eoq_flag, 1'b0);
      end
    end

    // R11: flag clear ignored while disabled
    mdis = 1'b1;
    pulse_clr(0);
    chk("R11", "flag clear ignored when disabled", eoq_flag, 1'b1);
    write_tcnt(16'h00AA);
    chk("R11", "tcnt write ignored when disabled", tcnt, tmod);
    mdis = 1'b0;
    pulse_clr(0);
    chk("R6", "flag clear when enabled", eoq_flag, 1'b0);
    chk("R6", "running after clear", running, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule